// File: doc/BRIEF.md
# Sixty-Four Source Interrupt Controller

This block gathers up to sixty-four active-low interrupt inputs and drives one request line to a processor. Each input passes through a two-flop synchronizer. It is then latched into a pending bit, either while it is held low or on a falling edge. A per-source enable bit gates the pending bit. Of the sources that are both pending and enabled, the lowest-numbered one is reported as the winner.

Software reaches the block through a small 32-bit register port. This port holds two enable words, two pending words that are cleared by writing one, a vector word and a sense-select word. It is a plain control port: every request is accepted in the cycle it is presented, and read data comes back exactly one cycle later.

Most sources are fixed to level-low detection. Two groups can be switched to falling-edge detection: sources 19..25 and sources 48..63. Source 0 does not exist, so a vector value of zero means that nothing is pending.

Top module: `intr_ctrl`

## Requirements
- R1: After reset, both enable words, both pending words and the sense word read zero, the vector reads zero and `irq_o` is low.
- R2: Word address 0 holds the enables for sources 32..63 (bit i is source 32+i), and word address 1 holds the enables for sources 0..31 (bit i is source i). A one enables a source. Both words read back exactly what was written.
- R3: Word address 2 holds pending bits for sources 32..63, and word address 3 holds pending bits for sources 0..31, with the same bit layout as the enable words. Writing a one to a bit clears that pending bit. Writing a zero leaves the bit unchanged.
- R4: In level mode, a source whose input is low becomes pending within three clock cycles. The bit stays pending after the input rises, until software clears it. If the input is still low when software clears the bit, it becomes pending again on the next cycle.
- R5: In edge mode, a source becomes pending only on a high-to-low transition of its input. Once cleared, the bit stays clear while the input remains low.
- R6: The sense word is at word address 5, and a one in a sense bit selects edge mode. Sources 19..25 use bit 14 minus (source − 19), and sources 48..63 use bit 31 minus (source − 48). The other sense bits ignore writes and read zero, and all other sources are always level-low.
- R7: The vector word is at word address 4. Its bits 31:26 hold the number of the lowest-numbered source that is both pending and enabled, and bits 25:0 read zero. Source 0 never becomes pending, so a field value of zero means that no enabled source is pending.
- R8: `irq_o` is high exactly when at least one pending source is also enabled.
- R9: A disabled source still latches and shows its pending bit, but it has no effect on `irq_o` or on the vector.
- R10: When a falling edge on an edge-mode source and a clear of that same bit reach the pending register in the same cycle, the edge wins and the bit remains pending.
- R11: A read request (`bus_sel_i` high, `bus_wr_i` low) returns its data on `bus_rdata_o` with `bus_rvalid_o` high for exactly the following cycle. Word addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_n_i | input | 64 | Active-low interrupt inputs, bit n is source n |
| bus_sel_i | input | 1 | Register access request |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with `bus_rvalid_o` |
| bus_rvalid_o | output | 1 | One-cycle read data strobe |
| irq_o | output | 1 | Processor interrupt request |

## Verification
Two functions can act on the same pending bit in the same cycle: the detection of a falling edge on an edge-mode source, and a software write that clears that bit. The bench provokes this by counting register stages from the input pin. It drives the input low and issues the clearing write so that the write is sampled on the edge where the detected fall is first presented to the pending register. A read afterwards must still show the bit set. In the same scenario, a steady-low input that is cleared in edge mode must stay clear, and in level mode it must come back the next cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC  = 64;
  localparam int DW    = 32;
  localparam int ID_W  = $clog2(NSRC);
  localparam int AW    = 3;
  localparam int VEC_LSB = DW - ID_W;

  localparam int EXT_FIRST  = 19;
  localparam int EXT_LAST   = 25;
  localparam int EXT_TOP    = 14;
  localparam int PORT_FIRST = 48;
  localparam int PORT_LAST  = 63;
  localparam int PORT_TOP   = 31;

  typedef enum logic [AW-1:0] {
    RA_EN_HI   = 3'd0,
    RA_EN_LO   = 3'd1,
    RA_PEND_HI = 3'd2,
    RA_PEND_LO = 3'd3,
    RA_VECTOR  = 3'd4,
    RA_SENSE   = 3'd5
  } reg_addr_e;

  function automatic bit src_has_sense(input int s);
    return (s >= EXT_FIRST && s <= EXT_LAST) || (s >= PORT_FIRST && s <= PORT_LAST);
  endfunction

  // Sense bit index counts downward as the source number rises.
  function automatic int sense_bit_of(input int s);
    if (s <= EXT_LAST) return EXT_TOP - (s - EXT_FIRST);
    else               return PORT_TOP - (s - PORT_FIRST);
  endfunction

  function automatic logic [DW-1:0] sense_wmask();
    logic [DW-1:0] m;
    m = '0;
    for (int s = 0; s < NSRC; s++)
      if (src_has_sense(s)) m[sense_bit_of(s)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int N      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_n_i,
  output logic [N-1:0] low_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] stg [STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '1;
      prev_q <= '1;
    end else begin
      stg[0] <= src_n_i;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      prev_q <= stg[STAGES-1];
    end
  end

  assign low_o  = ~stg[STAGES-1];
  assign fall_o = prev_q & ~stg[STAGES-1];

  // R5
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_o & $past(fall_o)) == '0);
endmodule

// File: rtl/intc_pend.sv
module intc_pend #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] low_i,
  input  logic [N-1:0] fall_i,
  input  logic [N-1:0] edge_sel_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  localparam logic [N-1:0] SRC_OK = {{(N-1){1'b1}}, 1'b0};

  logic [N-1:0] pend_q;
  logic [N-1:0] edge_nxt;
  logic [N-1:0] lvl_nxt;
  logic [N-1:0] pend_nxt;

  // Edge sources: a new fall beats a clear. Level sources: clear beats the
  // level, which sets the bit again one cycle later if still low.
  always_comb begin
    edge_nxt = (pend_q & ~clr_i) | fall_i;
    lvl_nxt  = ~clr_i & (pend_q | low_i);
    pend_nxt = SRC_OK & ((edge_sel_i & edge_nxt) | (~edge_sel_i & lvl_nxt));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_nxt;
  end

  assign pend_o = pend_q;

  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i));
  // R3
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & $past(clr_i & ~(edge_sel_i & fall_i))) == '0);
  // R4
  level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & $past(SRC_OK & ~edge_sel_i & low_i & ~clr_i))
      == $past(SRC_OK & ~edge_sel_i & low_i & ~clr_i));
  // R10
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & $past(SRC_OK & edge_sel_i & fall_i)) == $past(SRC_OK & edge_sel_i & fall_i));
  // R7
  no_src0_chk: assert property (@(posedge clk) disable iff (!rst_n) !pend_q[0]);
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int N    = 64,
  parameter int ID_W = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req_i,
  output logic            hit_o,
  output logic [ID_W-1:0] id_o
);
  always_comb begin
    hit_o = 1'b0;
    id_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        hit_o = 1'b1;
        id_o  = ID_W'(i);
      end
    end
  end

  // R7
  pick_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> req_i[id_o]);
  // R7
  pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> ((req_i & ((N'(1) << id_o) - N'(1))) == '0));
  // R8
  pick_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (req_i == '0));
endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_n_i,
  input  logic            bus_sel_i,
  input  logic            bus_wr_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  output logic            bus_rvalid_o,
  output logic            irq_o
);
  localparam logic [DW-1:0] SENSE_WM = sense_wmask();

  logic [NSRC-1:0] en_q;
  logic [DW-1:0]   sense_q;
  logic [NSRC-1:0] edge_sel;
  logic [NSRC-1:0] low_s;
  logic [NSRC-1:0] fall_s;
  logic [NSRC-1:0] clr;
  logic [NSRC-1:0] pend;
  logic            hit;
  logic [ID_W-1:0] win_id;
  logic [DW-1:0]   vec_word;
  logic [DW-1:0]   rd_mux;
  logic [DW-1:0]   rdata_q;
  logic            rvalid_q;
  logic            wr_en;
  logic            rd_en;

  assign wr_en = bus_sel_i & bus_wr_i;
  assign rd_en = bus_sel_i & ~bus_wr_i;

  // Per-source sense select from the packed sense word.
  for (genvar s = 0; s < NSRC; s++) begin : g_sense
    if (src_has_sense(s)) begin : g_prog
      assign edge_sel[s] = sense_q[sense_bit_of(s)];
    end else begin : g_fixed
      assign edge_sel[s] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      sense_q <= '0;
    end else if (wr_en) begin
      if (bus_addr_i == RA_EN_HI) en_q[NSRC-1:DW] <= bus_wdata_i;
      if (bus_addr_i == RA_EN_LO) en_q[DW-1:0]    <= bus_wdata_i;
      if (bus_addr_i == RA_SENSE) sense_q         <= bus_wdata_i & SENSE_WM;
    end
  end

  always_comb begin
    clr = '0;
    if (wr_en && bus_addr_i == RA_PEND_HI) clr[NSRC-1:DW] = bus_wdata_i;
    if (wr_en && bus_addr_i == RA_PEND_LO) clr[DW-1:0]    = bus_wdata_i;
  end

  intc_sync #(.N(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_n_i (src_n_i),
    .low_o   (low_s),
    .fall_o  (fall_s)
  );

  intc_pend #(.N(NSRC)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .low_i      (low_s),
    .fall_i     (fall_s),
    .edge_sel_i (edge_sel),
    .clr_i      (clr),
    .pend_o     (pend)
  );

  intc_pick #(.N(NSRC), .ID_W(ID_W)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (pend & en_q),
    .hit_o (hit),
    .id_o  (win_id)
  );

  assign vec_word = {win_id, {VEC_LSB{1'b0}}};

  always_comb begin
    case (bus_addr_i)
      RA_EN_HI:   rd_mux = en_q[NSRC-1:DW];
      RA_EN_LO:   rd_mux = en_q[DW-1:0];
      RA_PEND_HI: rd_mux = pend[NSRC-1:DW];
      RA_PEND_LO: rd_mux = pend[DW-1:0];
      RA_VECTOR:  rd_mux = vec_word;
      RA_SENSE:   rd_mux = sense_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;
  assign irq_o        = hit;

  // R7
  vec_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (win_id != '0));
  // R8
  irq_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en_q[win_id] && pend[win_id]));
  // R6
  sense_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_q & ~SENSE_WM) == '0);
endmodule

// File: tb/intr_ctrl_test.sv
`timescale 1ns/1ps
module intr_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_n = '1;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] exp_q [$];
  string       req_q [$];

  always #2.5 clk = ~clk;

  intr_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_n_i(src_n),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_rvalid_o(rvalid), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each returned read.
  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) chk("R11 unexpected rvalid", 32'd1, 32'd0);
      else chk(req_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, input logic [31:0] e, input string req);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    exp_q.push_back(e); req_q.push_back(req);
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    bus_rd(3'd0, 32'h0, "R1 en_hi");
    bus_rd(3'd1, 32'h0, "R1 en_lo");
    bus_rd(3'd2, 32'h0, "R1 pend_hi");
    bus_rd(3'd3, 32'h0, "R1 pend_lo");
    bus_rd(3'd4, 32'h0, "R1 vector");
    bus_rd(3'd5, 32'h0, "R1 sense");

    // R2 enable words
    bus_wr(3'd1, 32'hA5A5_0F0F);
    bus_wr(3'd0, 32'h1234_5678);
    bus_rd(3'd1, 32'hA5A5_0F0F, "R2 en_lo");
    bus_rd(3'd0, 32'h1234_5678, "R2 en_hi");
    bus_wr(3'd0, 32'h0);
    bus_wr(3'd1, 32'h0);

    // R4 / R9 level latching while disabled
    src_n[5] = 1'b0;
    wait_cyc(4);
    bus_rd(3'd3, 32'h0000_0020, "R4 level set");
    chk("R9 irq masked", {31'd0, irq}, 32'd0);
    bus_rd(3'd4, 32'h0, "R9 vector masked");
    src_n[5] = 1'b1;
    wait_cyc(4);
    bus_rd(3'd3, 32'h0000_0020, "R4 sticky after rise");
    // R3 write zero keeps, write one clears
    src_n[7] = 1'b0; wait_cyc(4); src_n[7] = 1'b1; wait_cyc(4);
    bus_wr(3'd3, 32'h0000_0080);
    bus_rd(3'd3, 32'h0000_0020, "R3 zero leaves bit");
    bus_wr(3'd3, 32'h0000_0020);
    bus_rd(3'd3, 32'h0, "R3 one clears");
    // R4 re-assert while still low
    src_n[5] = 1'b0; wait_cyc(4);
    bus_wr(3'd3, 32'h0000_0020);
    bus_rd(3'd3, 32'h0000_0020, "R4 reasserts");
    src_n[5] = 1'b1; wait_cyc(4);
    bus_wr(3'd3, 32'h0000_0020);
    bus_rd(3'd3, 32'h0, "R4 cleared after rise");

    // R6 sense map
    bus_wr(3'd5, 32'hFFFF_FFFF);
    bus_rd(3'd5, 32'hFFFF_7F00, "R6 writable bits");
    bus_wr(3'd5, 32'h0);

    // R5 edge mode on source 50 (sense bit 29, pending hi bit 18)
    bus_wr(3'd5, 32'h2000_0000);
    bus_wr(3'd0, 32'h0004_0000);
    src_n[50] = 1'b0; wait_cyc(4);
    bus_rd(3'd2, 32'h0004_0000, "R5 fall sets");
    chk("R8 irq high", {31'd0, irq}, 32'd1);
    bus_rd(3'd4, 32'd50 << 26, "R7 vector 50");
    bus_wr(3'd2, 32'h0004_0000);
    wait_cyc(3);
    bus_rd(3'd2, 32'h0, "R5 steady low stays clear");
    chk("R8 irq low", {31'd0, irq}, 32'd0);
    src_n[50] = 1'b1; wait_cyc(4);
    bus_rd(3'd2, 32'h0, "R5 rise ignored");

    // R6 source 25 uses bit 8
    bus_wr(3'd5, 32'h0000_0100);
    src_n[25] = 1'b0; wait_cyc(4);
    bus_rd(3'd3, 32'h0200_0000, "R6 src25 fall");
    bus_wr(3'd3, 32'h0200_0000);
    wait_cyc(3);
    bus_rd(3'd3, 32'h0, "R6 src25 is edge");
    src_n[25] = 1'b1; wait_cyc(4);

    // R10 fall and clear meet in the same cycle
    bus_wr(3'd5, 32'h2000_0000);
    @(negedge clk); src_n[50] = 1'b0;
    @(negedge clk);
    bus_wr(3'd2, 32'h0004_0000);
    bus_rd(3'd2, 32'h0004_0000, "R10 edge beats clear");
    bus_wr(3'd2, 32'h0004_0000);
    bus_rd(3'd2, 32'h0, "R10 later clear works");
    src_n[50] = 1'b1; wait_cyc(4);
    bus_wr(3'd5, 32'h0);

    // R7 priority across words
    bus_wr(3'd0, 32'hFFFF_FFFF);
    bus_wr(3'd1, 32'hFFFF_FFFF);
    src_n[40] = 1'b0; src_n[9] = 1'b0; wait_cyc(4);
    bus_rd(3'd4, 32'd9 << 26, "R7 lowest wins");
    src_n[9] = 1'b1; wait_cyc(4);
    bus_wr(3'd3, 32'h0000_0200);
    bus_rd(3'd4, 32'd40 << 26, "R7 next winner");
    chk("R8 irq with 40", {31'd0, irq}, 32'd1);
    src_n[40] = 1'b1; wait_cyc(4);
    bus_wr(3'd2, 32'h0000_0100);
    bus_rd(3'd4, 32'h0, "R7 none pending");
    chk("R8 irq none", {31'd0, irq}, 32'd0);
    src_n[0] = 1'b0; wait_cyc(4);
    bus_rd(3'd3, 32'h0, "R7 source 0 absent");
    chk("R7 irq src0", {31'd0, irq}, 32'd0);
    src_n[0] = 1'b1;

    // R11 read timing and unused addresses
    bus_rd(3'd6, 32'h0, "R11 addr 6");
    bus_rd(3'd7, 32'h0, "R11 addr 7");
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = 3'd0;
    exp_q.push_back(32'hFFFF_FFFF); req_q.push_back("R11 data");
    @(negedge clk); sel = 1'b0;
    chk("R11 rvalid next cycle", {31'd0, rvalid}, 32'd1);
    @(negedge clk);
    chk("R11 rvalid one cycle", {31'd0, rvalid}, 32'd0);

    wait_cyc(4);
    if (exp_q.size() != 0) chk("R11 reads outstanding", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule